// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a register-mapped watchdog. A down-counter is loaded from a table of sixteen power-of-two periods. Software sets a sticky enable bit to start it. The first count uses a separate initial period. After that, software must write a fixed key value to a restart register before the counter runs out.

A mode bit selects one of two responses to expiry. In the direct response, expiry raises a system reset request at once. In the two-stage response, the first expiry raises a pending interrupt and reloads the counter. Only a second expiry with no restart in between raises the reset request. The effective timeout in that mode is twice the selected period.

The reset request is a pulse of fixed length, and the counter holds at zero while the pulse is high. Reset generation itself and the bus bridge sit outside the block.

Controller states, all named:
- WD_OFF: disabled.
- WD_STAGE1: first stage.
- WD_STAGE2: second stage, interrupt pending.
- WD_FIRE: reset pulse active.

Transitions, all named:
- arm: WD_OFF to WD_STAGE1, on an enable write.
- kick: WD_STAGE1 or WD_STAGE2 to WD_STAGE1, on a key write.
- warn: WD_STAGE1 to WD_STAGE2, on expiry in two-stage mode.
- bite: WD_STAGE1 to WD_FIRE on expiry in direct mode, or WD_STAGE2 to WD_FIRE on any expiry.
- rearm: WD_FIRE to WD_STAGE1, when the pulse ends.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, the block is disabled and both outputs are low. The control, range and count registers read zero.
- R2: The control register is at offset 0x00, with bit 0 as enable and bit 1 as mode (1 = two-stage). It reads back as {mode, enable}. A write cannot clear enable once it is set, but mode can be written at any time.
- R3: The range register is at offset 0x04. Bits [3:0] select the active period index and bits [7:4] select the initial period index, and the register reads back as written. Index n means a period of 2^(PSHIFT+n) clock cycles.
- R4: The edge that writes enable (arm) loads the initial period. In direct mode the reset request rises exactly one period of edges after that write edge.
- R5: The reset request stays high for exactly RST_CYCLES cycles, and the counter reads zero during that time. After the pulse, the counter reloads from the active period and the first stage restarts, so the next request follows one period after the pulse ends.
- R6: In two-stage mode, the interrupt rises one period after the arm or kick edge and the counter reloads from the active period. The reset request rises one further period later unless a kick arrives first.
- R7: Writing 0x76 to offset 0x0C while enabled is a kick. It reloads the active period, clears the interrupt and returns to the first stage. Any other value written there has no effect.
- R8: A raised interrupt stays high until one of three events: a kick, a read of offset 0x14, or the end of a reset pulse. A read of offset 0x14 does not restart or move the counter.
- R9: Read data appears one cycle after the read strobe. Offset 0x10 and offset 0x14 read 1 while the interrupt is pending and 0 otherwise. Offset 0x08 reads the live counter. Unmapped offsets read zero.
- R10: If a kick lands on the same edge as an expiry, the kick wins: no interrupt and no reset request occur, and the counter reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered, valid the cycle after a read strobe |
| irq_o | output | 1 | Pending first-stage interrupt (level) |
| sys_rst_req_o | output | 1 | System reset request pulse |

## Verification
Each result has a fixed due time:
- A register write takes effect on the edge that samples it.
- Read data is due one edge after the read strobe.
- The interrupt and the reset request rise exactly one period of edges after the arm or kick edge.
- The reset request stays high for RST_CYCLES edges.

The bench counts rising edges in a free-running counter and samples every output on falling edges. Its directed checks compare the edge count at which each output changes against the period arithmetic. A behavioural reference model is stepped on the same rising edges and compared with all three outputs on every falling edge. This pins the kick-on-expiry race, the read-to-clear path and the reload after the pulse to their exact cycles.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Register byte offsets
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_RANGE = 8'h04;
    localparam logic [7:0] OFS_COUNT = 8'h08;
    localparam logic [7:0] OFS_KICK  = 8'h0C;
    localparam logic [7:0] OFS_ISTAT = 8'h10;
    localparam logic [7:0] OFS_ICLR  = 8'h14;

    typedef enum logic [1:0] {
        WD_OFF    = 2'd0,
        WD_STAGE1 = 2'd1,
        WD_STAGE2 = 2'd2,
        WD_FIRE   = 2'd3
    } wd_state_e;

endpackage

// File: rtl/wdog_period.sv
module wdog_period #(
    parameter int PSHIFT = 16,
    parameter int CNT_W  = PSHIFT + 16
) (
    input  logic [3:0]       idx_i,
    output logic [CNT_W-1:0] load_o
);

    // Reload value is one less than the period so expiry lands on edge N
    always_comb begin
        load_o = (CNT_W'(1) << (PSHIFT + int'(idx_i))) - CNT_W'(1);
    end

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 32,
    parameter int          CNT_W    = 32,
    parameter logic [7:0]  KICK_KEY = 8'h76
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              irq_i,
    output logic              en_o,
    output logic              mode_o,
    output logic [3:0]        tsel_o,
    output logic [3:0]        tinit_o,
    output logic              arm_o,
    output logic              kick_o,
    output logic              clr_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic              en_q, mode_q;
    logic [3:0]        tsel_q, tinit_q;
    logic [DATA_W-1:0] rdata_q, rd_mux;
    logic              wr_hit, rd_hit;

    assign wr_hit = sel_i && wr_i;
    assign rd_hit = sel_i && !wr_i;

    assign arm_o  = wr_hit && (addr_i == ADDR_W'(OFS_CTRL)) && wdata_i[0] && !en_q;
    assign kick_o = wr_hit && (addr_i == ADDR_W'(OFS_KICK))
                    && (wdata_i == DATA_W'(KICK_KEY)) && en_q;
    assign clr_o  = rd_hit && (addr_i == ADDR_W'(OFS_ICLR));

    always_comb begin
        rd_mux = '0;
        if (addr_i == ADDR_W'(OFS_CTRL))       rd_mux = DATA_W'({mode_q, en_q});
        else if (addr_i == ADDR_W'(OFS_RANGE)) rd_mux = DATA_W'({tinit_q, tsel_q});
        else if (addr_i == ADDR_W'(OFS_COUNT)) rd_mux = DATA_W'(cnt_i);
        else if (addr_i == ADDR_W'(OFS_ISTAT)) rd_mux = DATA_W'(irq_i);
        else if (addr_i == ADDR_W'(OFS_ICLR))  rd_mux = DATA_W'(irq_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            mode_q  <= 1'b0;
            tsel_q  <= '0;
            tinit_q <= '0;
            rdata_q <= '0;
        end else begin
            if (wr_hit && addr_i == ADDR_W'(OFS_CTRL)) begin
                en_q   <= en_q | wdata_i[0];
                mode_q <= wdata_i[1];
            end
            if (wr_hit && addr_i == ADDR_W'(OFS_RANGE)) begin
                tsel_q  <= wdata_i[3:0];
                tinit_q <= wdata_i[7:4];
            end
            if (rd_hit) rdata_q <= rd_mux;
        end
    end

    assign en_o    = en_q;
    assign mode_o  = mode_q;
    assign tsel_o  = tsel_q;
    assign tinit_o = tinit_q;
    assign rdata_o = rdata_q;

endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int RST_CYCLES = 8,
    localparam int PLS_W     = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             kick_i,
    input  logic             clr_i,
    input  logic             mode_i,
    input  logic [CNT_W-1:0] init_load_i,
    input  logic [CNT_W-1:0] sel_load_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o,
    output logic             fire_o
);

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             irq_q, irq_d;
    logic [PLS_W-1:0] pls_q, pls_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
            cnt_q   <= '0;
            irq_q   <= 1'b0;
            pls_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            irq_q   <= irq_d;
            pls_q   <= pls_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        irq_d   = clr_i ? 1'b0 : irq_q;
        pls_d   = pls_q;
        unique case (state_q)
            WD_OFF: begin
                if (arm_i) begin
                    state_d = WD_STAGE1;
                    cnt_d   = init_load_i;
                end
            end
            WD_STAGE1: begin
                if (kick_i) begin
                    cnt_d = sel_load_i;
                    irq_d = 1'b0;
                end else if (cnt_q == '0) begin
                    if (mode_i) begin
                        state_d = WD_STAGE2;
                        cnt_d   = sel_load_i;
                        irq_d   = 1'b1;
                    end else begin
                        state_d = WD_FIRE;
                        pls_d   = PLS_W'(RST_CYCLES - 1);
                    end
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            WD_STAGE2: begin
                if (kick_i) begin
                    state_d = WD_STAGE1;
                    cnt_d   = sel_load_i;
                    irq_d   = 1'b0;
                end else if (cnt_q == '0) begin
                    state_d = WD_FIRE;
                    pls_d   = PLS_W'(RST_CYCLES - 1);
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            WD_FIRE: begin
                if (pls_q == '0) begin
                    state_d = WD_STAGE1;
                    cnt_d   = sel_load_i;
                    irq_d   = 1'b0;
                end else begin
                    pls_d = pls_q - PLS_W'(1);
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        cnt_o  = cnt_q;
        irq_o  = irq_q;
        fire_o = (state_q == WD_FIRE);
    end

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
    parameter int         ADDR_W     = 8,
    parameter int         DATA_W     = 32,
    parameter int         PSHIFT     = 16,
    parameter int         RST_CYCLES = 8,
    parameter logic [7:0] KICK_KEY   = 8'h76,
    localparam int        CNT_W      = PSHIFT + 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              sys_rst_req_o
);

    logic             en_w, mode_w, arm_w, kick_w, clr_w, irq_w, fire_w;
    logic [3:0]       tsel_w, tinit_w;
    logic [CNT_W-1:0] cnt_w;
    logic [3:0]       pidx  [2];
    logic [CNT_W-1:0] pload [2];

    wdog_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .KICK_KEY(KICK_KEY)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
        .cnt_i(cnt_w), .irq_i(irq_w),
        .en_o(en_w), .mode_o(mode_w), .tsel_o(tsel_w), .tinit_o(tinit_w),
        .arm_o(arm_w), .kick_o(kick_w), .clr_o(clr_w), .rdata_o(bus_rdata)
    );

    assign pidx[0] = tinit_w;
    assign pidx[1] = tsel_w;

    for (genvar g = 0; g < 2; g++) begin : g_per
        wdog_period #(.PSHIFT(PSHIFT), .CNT_W(CNT_W)) u_per (
            .idx_i(pidx[g]), .load_o(pload[g])
        );
    end

    wdog_core #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_core (
        .clk(clk), .rst_n(rst_n),
        .arm_i(arm_w), .kick_i(kick_w), .clr_i(clr_w), .mode_i(mode_w),
        .init_load_i(pload[0]), .sel_load_i(pload[1]),
        .cnt_o(cnt_w), .irq_o(irq_w), .fire_o(fire_w)
    );

    assign irq_o         = irq_w;
    assign sys_rst_req_o = fire_w;

endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk
    import wdog_pkg::*;
#(
    parameter int         ADDR_W     = 8,
    parameter int         DATA_W     = 32,
    parameter int         CNT_W      = 32,
    parameter int         RST_CYCLES = 8,
    parameter logic [7:0] KICK_KEY   = 8'h76
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq_o,
    input logic              sys_rst_req_o,
    input logic              en_w,
    input logic              mode_w,
    input logic [CNT_W-1:0]  cnt_w
);

    logic        kick_seen, clr_seen;
    logic [15:0] run_q;

    assign kick_seen = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_KICK))
                       && (bus_wdata == DATA_W'(KICK_KEY)) && en_w;
    assign clr_seen  = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_ICLR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             run_q <= '0;
        else if (sys_rst_req_o) run_q <= run_q + 16'd1;
        else                    run_q <= '0;
    end

    // R2
    en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_w |=> en_w);

    // R5
    fire_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req_o |-> (cnt_w == '0));

    // R5
    fire_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_req_o) |-> (run_q == 16'(RST_CYCLES)));

    // R6
    irq_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(mode_w));

    // R7
    kick_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_seen && !sys_rst_req_o) |=> !irq_o);

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !kick_seen && !clr_seen && !sys_rst_req_o) |=> irq_o);

    // R8
    clr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_seen && irq_o) |=> !irq_o);

endmodule

bind wdog_two_stage wdog_two_stage_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .RST_CYCLES(RST_CYCLES), .KICK_KEY(KICK_KEY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_o(irq_o),
    .sys_rst_req_o(sys_rst_req_o), .en_w(en_w), .mode_w(mode_w), .cnt_w(cnt_w)
);

// File: tb/wdog_two_stage_bench.sv
`timescale 1ns/1ps
module wdog_two_stage_bench;

    localparam int PSHIFT = 2;
    localparam int RSTC   = 4;
    localparam int LIMIT  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, sys_rst_req_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    wdog_two_stage #(.PSHIFT(PSHIFT), .RST_CYCLES(RSTC)) u_wdog_two_stage (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .sys_rst_req_o(sys_rst_req_o)
    );

    // ---------------- reference model ----------------
    int m_st, m_cnt, m_irq, m_pls, m_en, m_mode, m_tsel, m_tinit, m_rdata;
    int n_st, n_cnt, n_irq, n_pls;
    bit kick, arm, clr;

    function automatic int per(input int n);
        return 1 << (PSHIFT + n);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_irq = 0; m_pls = 0;
            m_en = 0; m_mode = 0; m_tsel = 0; m_tinit = 0; m_rdata = 0;
        end else begin
            kick = bus_sel && bus_wr && bus_addr == 8'h0C && bus_wdata == 32'h76 && m_en != 0;
            arm  = bus_sel && bus_wr && bus_addr == 8'h00 && bus_wdata[0] && m_en == 0;
            clr  = bus_sel && !bus_wr && bus_addr == 8'h14;
            if (bus_sel && !bus_wr) begin
                case (bus_addr)
                    8'h00:   m_rdata = m_mode * 2 + m_en;
                    8'h04:   m_rdata = m_tinit * 16 + m_tsel;
                    8'h08:   m_rdata = m_cnt;
                    8'h10:   m_rdata = m_irq;
                    8'h14:   m_rdata = m_irq;
                    default: m_rdata = 0;
                endcase
            end
            n_st = m_st; n_cnt = m_cnt; n_pls = m_pls;
            n_irq = clr ? 0 : m_irq;
            if (m_st == 0) begin
                if (arm) begin n_st = 1; n_cnt = per(m_tinit) - 1; end
            end else if (m_st == 3) begin
                if (m_pls == 0) begin n_st = 1; n_cnt = per(m_tsel) - 1; n_irq = 0; end
                else n_pls = m_pls - 1;
            end else if (kick) begin
                n_st = 1; n_cnt = per(m_tsel) - 1; n_irq = 0;
            end else if (m_cnt == 0) begin
                if (m_st == 1 && m_mode != 0) begin
                    n_st = 2; n_cnt = per(m_tsel) - 1; n_irq = 1;
                end else begin
                    n_st = 3; n_pls = RSTC - 1;
                end
            end else begin
                n_cnt = m_cnt - 1;
            end
            m_st = n_st; m_cnt = n_cnt; m_irq = n_irq; m_pls = n_pls;
            if (bus_sel && bus_wr && bus_addr == 8'h00) begin
                m_en   = (m_en != 0 || bus_wdata[0]) ? 1 : 0;
                m_mode = bus_wdata[1] ? 1 : 0;
            end
            if (bus_sel && bus_wr && bus_addr == 8'h04) begin
                m_tsel  = int'(bus_wdata[3:0]);
                m_tinit = int'(bus_wdata[7:4]);
            end
        end
    end

    // Per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks += 3;
            if (irq_o !== (m_irq != 0)) begin
                fails++;
                $display("FAIL R8 model irq at cycle %0d: got %0b expected %0d", cyc, irq_o, m_irq);
            end
            if (sys_rst_req_o !== (m_st == 3)) begin
                fails++;
                $display("FAIL R5 model reset request at cycle %0d: got %0b expected %0b",
                         cyc, sys_rst_req_o, m_st == 3);
            end
            if (bus_rdata !== 32'(m_rdata)) begin
                fails++;
                $display("FAIL R9 model read data at cycle %0d: got %0h expected %0h",
                         cyc, bus_rdata, m_rdata);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic report();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc == LIMIT) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run exceeded %0d cycles (got hang, expected completion)", LIMIT);
            report();
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Tasks are entered at a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = int'(bus_rdata);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bus_sel = 1'b0; bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // ---------------- directed scenarios ----------------
    initial begin
        int v, t0, ta, k, k2, t1;
        @(negedge clk);
        do_reset();

        // R1: reset state
        check("R1 irq after reset", int'(irq_o), 0);
        check("R1 reset request after reset", int'(sys_rst_req_o), 0);
        rd(8'h00, v); check("R1 control reads zero", v, 0);
        rd(8'h04, v); check("R1 range reads zero", v, 0);
        rd(8'h08, v); check("R1 count reads zero", v, 0);
        rd(8'h3C, v); check("R9 unmapped offset reads zero", v, 0);

        // Direct mode: initial index 1 (8 cycles), active index 0 (4 cycles)
        wr(8'h04, 32'h10);
        rd(8'h04, v); check("R3 range readback", v, 32'h10);
        wr(8'h00, 32'h1);
        t0 = cyc;
        while (!sys_rst_req_o) @(negedge clk);
        check("R4 direct-mode expiry uses initial period", cyc - t0, 8);
        ta = cyc;
        while (sys_rst_req_o) @(negedge clk);
        check("R5 reset pulse length", cyc - ta, RSTC);
        while (!sys_rst_req_o) @(negedge clk);
        check("R5 reload from active period after pulse", cyc - ta, RSTC + 4);
        wr(8'h00, 32'h0);
        rd(8'h00, v); check("R2 enable cannot be cleared", v, 1);
        wr(8'h00, 32'h2);
        rd(8'h00, v); check("R2 mode writable, reads {mode,en}", v, 3);

        // Two-stage mode, both indices 2 (16 cycles)
        do_reset();
        wr(8'h04, 32'h22);
        wr(8'h00, 32'h3);
        t0 = cyc;
        while (!irq_o) @(negedge clk);
        check("R6 interrupt after one period", cyc - t0, 16);
        check("R3 index 2 gives 16 cycles", cyc - t0, per(2));
        while (!sys_rst_req_o) @(negedge clk);
        check("R6 reset after second period", cyc - t0, 32);
        check("R8 interrupt still pending during pulse", int'(irq_o), 1);
        while (sys_rst_req_o) @(negedge clk);
        check("R8 interrupt cleared at pulse end", int'(irq_o), 0);

        // Kick, bad key, kick-on-expiry, read-to-clear
        do_reset();
        wr(8'h04, 32'h22);
        wr(8'h00, 32'h3);
        t0 = cyc;
        repeat (4) @(negedge clk);
        wr(8'h0C, 32'h75);
        while (!irq_o) @(negedge clk);
        check("R7 wrong key has no effect on timing", cyc - t0, 16);
        wr(8'h0C, 32'h76);
        k = cyc;
        check("R7 kick clears interrupt", int'(irq_o), 0);
        rd(8'h08, v); check("R9 live count after kick", v, 15);
        repeat (14) @(negedge clk);
        wr(8'h0C, 32'h76);
        k2 = cyc;
        check("R10 kick on expiry edge", k2 - k, 16);
        check("R10 no interrupt when kick meets expiry", int'(irq_o), 0);
        while (!irq_o && !sys_rst_req_o) @(negedge clk);
        check("R10 counter reloaded by winning kick", cyc - k2, 16);
        t1 = cyc;
        rd(8'h10, v); check("R9 status reads pending", v, 1);
        rd(8'h14, v); check("R9 clear register returns pending", v, 1);
        check("R8 read of clear register drops interrupt", int'(irq_o), 0);
        rd(8'h10, v); check("R9 status reads zero after clear", v, 0);
        while (!sys_rst_req_o) @(negedge clk);
        check("R8 clear read does not restart stage", cyc - t1, 16);

        repeat (2) @(negedge clk);
        report();
    end

endmodule